// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a fast core clock into the bit-level timing a CAN controller needs. Two byte-wide timing registers set it up. The core clock is halved and then divided by a prescaler to form the time quantum. Each nominal bit is a one-quantum sync segment, then a first phase segment, then a second phase segment. The receive line is sampled where the first phase segment ends. Depending on a mode bit, the sampled value comes from one sample or from a majority vote over three consecutive quanta.

Falling (recessive-to-dominant) edges on the receive line keep the local bit clock aligned to the bus. While the bus is idle, an edge restarts the bit at once. During traffic, an edge stretches the first phase segment or trims the second one, but never by more than the jump width. Only one such correction is allowed per bit.

The controller writes the timing bytes while the enable input is low. The block then runs from that snapshot once enable is raised. Frame decoding, stuffing, CRC and error counting belong to other blocks.

Top module: `can_bit_timer`

## Requirements
- R1: With prescaler field P = `cfg_b0[5:0]`, `tq_tick` pulses for one clock every 2*(P+1) core clocks while running.
- R2: With TS1 = `cfg_b1[3:0]` and TS2 = `cfg_b1[6:4]`, an uncorrected bit lasts TS1+TS2+3 quanta. `bit_start` pulses together with the `tq_tick` that begins the sync quantum (quantum index 0).
- R3: `sample_stb` pulses with the `tq_tick` that ends quantum TS1+1, which is TS1+2 ticks after the `bit_start` tick. `rx_bit` takes the sampled value in the following clock and holds it until the next sample.
- R4: When `cfg_b1[7]` is 1, the sampled value is the majority of the line values in quanta TS1-1, TS1 and TS1+1. When it is 0, only quantum TS1+1 counts.
- R5: A falling edge of `rx` inside quantum k while `bus_idle` is 1 ends the bit at the end of that quantum: `bit_start` pulses there, the bit lasts k+1 quanta, and no sample is taken in it.
- R6: A falling edge inside quantum k, with 1 <= k <= TS1+1 and `bus_idle` 0, lengthens the bit and delays the sample point by min(k, J+1) quanta, where J = `cfg_b0[7:6]`.
- R7: A falling edge inside quantum k, with k > TS1+1 and `bus_idle` 0, shortens the bit by min(N-1-k, J+1) quanta, where N = TS1+TS2+3.
- R8: A falling edge inside the sync quantum changes nothing. After one correction in a bit, any further edge in that bit is ignored. Rising edges never correct.
- R9: The timing bytes are captured only while `en` is 0; changes made while `en` is 1 have no effect. While `en` is 0, `tq_tick`, `sample_stb` and `bit_start` stay low, and a bit restarts at quantum 0 once `en` rises.
- R10: After reset, the three strobes are low and `rx_bit` is 1.
- R11: `sample_stb` and `bit_start` never pulse in the same clock, and neither pulses without `tq_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; timing bytes are captured while low |
| cfg_b0 | input | 8 | Jump width [7:6], prescaler [5:0] |
| cfg_b1 | input | 8 | Triple-sample mode [7], TS2 [6:4], TS1 [3:0] |
| rx | input | 1 | Receive line, 1 = recessive |
| bus_idle | input | 1 | High when no frame is in progress |
| tq_tick | output | 1 | One-clock pulse per time quantum |
| sample_stb | output | 1 | Pulse at the sample point |
| rx_bit | output | 1 | Most recently sampled bit |
| bit_start | output | 1 | Pulse at the start of each bit |

## Verification
The checker watches every cycle for four things: the quantum spacing against the captured prescaler, that the strobes are exclusive and aligned to ticks, that the block is quiet while disabled, and that `rx_bit` changes only right after a sample strobe. The bench sweeps every segment-length combination at two prescaler values and several large prescalers, measuring bit length and sample offset in ticks. Scenarios alone show the edge corrections: falling edges placed in each quantum under every jump width, hard synchronisation, a second edge in one bit, and majority against single sampling. The bench also changes the configuration while running to confirm it is ignored.

// File: rtl/can_bt_pkg.sv
// Shared widths and the configuration record for the CAN bit timing block.
// Assumes the timing bytes pack as {jump width, prescaler} and
// {sample mode, second segment, first segment}.
package can_bt_pkg;
    localparam int SJW_W = 2;
    localparam int BRP_W = 6;
    localparam int TS1_W = 4;
    localparam int TS2_W = 3;
    localparam int CFG_W = SJW_W + BRP_W + 1 + TS2_W + TS1_W;
    // Longest bit plus the largest correction, with one bit of margin
    localparam int Q_W   = $clog2((1 << TS1_W) + (1 << TS2_W) + (1 << SJW_W) + 2) + 1;

    typedef struct packed {
        logic [SJW_W-1:0] sjw;
        logic [BRP_W-1:0] brp;
        logic             sam;
        logic [TS2_W-1:0] tseg2;
        logic [TS1_W-1:0] tseg1;
    } bt_cfg_t;
endpackage

// File: rtl/can_bt_prescaler.sv
// Quantum generator: emits one tick every 2*(brp+1) clocks while run is high.
// Assumes brp is stable while run is high.
module can_bt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [BRP_W-1:0] brp,
    output logic             tq_tick
);
    localparam int CNT_W = BRP_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit   = {brp, 1'b1};
    assign tq_tick = run && (cnt == limit);

    // Count core clocks within one quantum
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/can_bt_edge.sv
// Receive-line register and falling-edge catcher. A falling edge is held
// pending until the next quantum tick consumes it.
// Assumes rx is already synchronous to clk.
module can_bt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rx,
    input  logic tq_tick,
    output logic rx_s,
    output logic edge_now
);
    logic rx_d;
    logic fall;
    logic pend;

    assign fall     = rx_d && !rx_s;
    assign edge_now = pend || fall;

    // Register the line twice for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            rx_s <= 1'b1;
            rx_d <= 1'b1;
        end else begin
            rx_s <= rx;
            rx_d <= rx_s;
        end
    end

    // Hold a detected edge until a tick takes it
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tq_tick) begin
            pend <= 1'b0;
        end else if (fall) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/can_bt_seq.sv
// Quantum sequencer: counts quanta in a bit, places the sample point and the
// bit boundary, and applies hard or soft edge corrections.
// Assumes an edge is reported in the tick that ends the quantum holding it.
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tq_tick,
    input  logic             edge_now,
    input  logic             bus_idle,
    input  logic [SJW_W-1:0] sjw,
    input  logic [TS1_W-1:0] tseg1,
    input  logic [TS2_W-1:0] tseg2,
    output logic             sample_stb,
    output logic             bit_start
);
    logic [Q_W-1:0] q;
    logic [Q_W-1:0] ext;
    logic [Q_W-1:0] shr;
    logic           resynced;

    logic [Q_W-1:0] n_bits, sp_base, jump, late_amt, early_amt;
    logic [Q_W-1:0] ext_eff, shr_eff, last_q;
    logic           hard, late, early, bit_end;

    // Segment geometry and correction amounts for the current quantum
    always_comb begin
        n_bits    = Q_W'(tseg1) + Q_W'(tseg2) + Q_W'(3);
        sp_base   = Q_W'(tseg1) + Q_W'(1);
        jump      = Q_W'(sjw) + Q_W'(1);
        hard      = tq_tick && edge_now && bus_idle;
        late      = tq_tick && edge_now && !bus_idle && !resynced
                    && (q != '0) && (q <= sp_base);
        early     = tq_tick && edge_now && !bus_idle && !resynced
                    && (q > sp_base);
        late_amt  = (q < jump) ? q : jump;
        early_amt = ((n_bits - Q_W'(1) - q) < jump) ? (n_bits - Q_W'(1) - q) : jump;
        ext_eff   = late  ? late_amt  : ext;
        shr_eff   = early ? early_amt : shr;
        last_q    = n_bits - Q_W'(1) + ext_eff - shr_eff;
        bit_end   = tq_tick && (hard || (q >= last_q));
    end

    assign bit_start  = bit_end;
    assign sample_stb = tq_tick && !hard && (q == sp_base + ext_eff);

    // Advance the quantum index and remember this bit's correction
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            q        <= '0;
            ext      <= '0;
            shr      <= '0;
            resynced <= 1'b0;
        end else if (tq_tick) begin
            if (bit_end) begin
                q        <= '0;
                ext      <= '0;
                shr      <= '0;
                resynced <= 1'b0;
            end else begin
                q        <= q + Q_W'(1);
                ext      <= ext_eff;
                shr      <= shr_eff;
                resynced <= resynced || late || early;
            end
        end
    end
endmodule

// File: rtl/can_bt_sampler.sv
// Bit sampler: keeps the line value of recent quanta and, at the sample
// strobe, latches either the last value or a three-quantum majority.
// Assumes sample_stb only pulses together with tq_tick.
module can_bt_sampler #(
    parameter int HIST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tq_tick,
    input  logic sample_stb,
    input  logic sam,
    input  logic rx_s,
    output logic rx_bit
);
    logic [HIST-1:0] hist;
    logic [HIST:0]   win;
    logic            vote;

    assign win  = {hist, rx_s};
    assign vote = (win[0] && win[1]) || (win[0] && win[2]) || (win[1] && win[2]);

    // Shift the line value in on every quantum tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hist <= '1;
        end else if (tq_tick) begin
            hist <= win[HIST-1:0];
        end
    end

    // Latch the sampled bit at the sample point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_bit <= 1'b1;
        end else if (sample_stb) begin
            rx_bit <= sam ? vote : rx_s;
        end
    end
endmodule

// File: rtl/can_bit_timer.sv
// CAN bit timing top: snapshots the timing bytes while disabled, then drives
// the quantum, sample and bit-start strobes and the sampled bit.
// Assumes rx and bus_idle are synchronous to clk.
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] cfg_b0,
    input  logic [7:0] cfg_b1,
    input  logic       rx,
    input  logic       bus_idle,
    output logic       tq_tick,
    output logic       sample_stb,
    output logic       rx_bit,
    output logic       bit_start
);
    bt_cfg_t          cfg_q;
    logic [BRP_W-1:0] cfg_brp;
    logic             rx_s;
    logic             edge_now;

    assign cfg_brp = cfg_q.brp;

    // Capture the timing bytes only while the block is stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!en) begin
            cfg_q <= bt_cfg_t'({cfg_b0, cfg_b1});
        end
    end

    can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(en), .brp(cfg_q.brp), .tq_tick(tq_tick)
    );

    can_bt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .run(en), .rx(rx), .tq_tick(tq_tick),
        .rx_s(rx_s), .edge_now(edge_now)
    );

    can_bt_seq u_seq (
        .clk(clk), .rst_n(rst_n), .run(en), .tq_tick(tq_tick),
        .edge_now(edge_now), .bus_idle(bus_idle), .sjw(cfg_q.sjw),
        .tseg1(cfg_q.tseg1), .tseg2(cfg_q.tseg2),
        .sample_stb(sample_stb), .bit_start(bit_start)
    );

    can_bt_sampler #(.HIST(2)) u_smp (
        .clk(clk), .rst_n(rst_n), .run(en), .tq_tick(tq_tick),
        .sample_stb(sample_stb), .sam(cfg_q.sam), .rx_s(rx_s), .rx_bit(rx_bit)
    );
endmodule

// File: rtl/can_bit_timer_chk.sv
// Checker for the CAN bit timing top, bound into every instance.
// Assumes the captured prescaler is brought out as cfg_brp.
module can_bit_timer_chk #(
    parameter int BRP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tq_tick,
    input logic             sample_stb,
    input logic             bit_start,
    input logic             rx_bit,
    input logic [BRP_W-1:0] brp
);
    logic [BRP_W:0] gap;

    // Clocks elapsed since the last quantum tick while running
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tq_tick) begin
            gap <= '0;
        end else begin
            gap <= gap + (BRP_W+1)'(1);
        end
    end

    assert_tq_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tq_tick |-> (gap == {brp, 1'b1}));

    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, bit_start}));

    assert_strobe_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb || bit_start) |-> tq_tick);

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(tq_tick || sample_stb || bit_start));

    assert_bit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_stb) |-> $stable(rx_bit));
endmodule

bind can_bit_timer can_bit_timer_chk #(.BRP_W(can_bt_pkg::BRP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .tq_tick(tq_tick),
    .sample_stb(sample_stb), .bit_start(bit_start), .rx_bit(rx_bit),
    .brp(cfg_brp)
);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] cfg_b0 = 8'h00;
    logic [7:0] cfg_b1 = 8'h00;
    logic       rx = 1'b1;
    logic       bus_idle = 1'b0;
    logic       tq_tick, sample_stb, rx_bit, bit_start;

    int checks = 0;
    int fails = 0;
    int tcount = 0, last_bs = 0, prev_len = 0, samp_off = 0;
    int cyc = 0, tq_len = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_b0(cfg_b0), .cfg_b1(cfg_b1),
        .rx(rx), .bus_idle(bus_idle), .tq_tick(tq_tick), .sample_stb(sample_stb),
        .rx_bit(rx_bit), .bit_start(bit_start)
    );

    // Measure quantum spacing, bit lengths and sample offsets in ticks
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (tq_tick) begin
            tq_len = cyc;
            cyc = 0;
            tcount = tcount + 1;
            if (bit_start) begin
                prev_len = tcount - last_bs;
                last_bs = tcount;
            end
            if (sample_stb) samp_off = tcount - last_bs;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_bs();
        do @(negedge clk); while (!bit_start);
        #1;
    endtask

    task automatic wait_ticks(input int k);
        for (int i = 0; i < k; i++) begin
            do @(negedge clk); while (!tq_tick);
        end
    endtask

    task automatic start_cfg(input logic [7:0] b0, input logic [7:0] b1);
        @(negedge clk);
        en = 1'b0;
        cfg_b0 = b0;
        cfg_b1 = b1;
        repeat (3) @(negedge clk);
        en = 1'b1;
    endtask

    // Falling edge in quantum k; returns the length of that bit in quanta
    task automatic edge_at(input int k, input bit idle, output int len, output int off);
        wait_bs();
        wait_ticks(k);
        bus_idle = idle;
        rx = 1'b0;
        wait_bs();
        len = prev_len;
        off = samp_off;
        rx = 1'b1;
        bus_idle = 1'b0;
    endtask

    initial begin
        int len, off, exp, n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!tq_tick && !sample_stb && !bit_start, "R10 strobes", {tq_tick, sample_stb, bit_start}, 0);
        check(rx_bit == 1'b1, "R10 rx_bit", rx_bit, 1);

        // R1 R2 R3: sweep all segment lengths at two prescalers
        for (int b = 0; b < 2; b++) begin
            for (int t1 = 0; t1 < 16; t1++) begin
                for (int t2 = 0; t2 < 8; t2++) begin
                    start_cfg(8'(b), {1'b0, 3'(t2), 4'(t1)});
                    wait_bs();
                    wait_bs();
                    check(prev_len == t1 + t2 + 3, "R2 bit length", prev_len, t1 + t2 + 3);
                    check(samp_off == t1 + 2, "R3 sample offset", samp_off, t1 + 2);
                    check(tq_len == 2 * (b + 1), "R1 quantum", tq_len, 2 * (b + 1));
                end
            end
        end
        // R1: large prescalers
        for (int b = 5; b < 64; b += 29) begin
            start_cfg(8'(b), 8'h00);
            wait_bs();
            wait_bs();
            check(tq_len == 2 * (b + 1), "R1 quantum large", tq_len, 2 * (b + 1));
            check(prev_len == 3, "R2 minimum bit", prev_len, 3);
        end

        // Fixed geometry for corrections: TS1=5, TS2=4, N=12
        n = 12;
        for (int j = 0; j < 4; j++) begin
            start_cfg({2'(j), 6'd0}, {1'b0, 3'd4, 4'd5});
            wait_bs();
            // R8: edge in sync quantum
            edge_at(0, 1'b0, len, off);
            check(len == n, "R8 sync edge", len, n);
            // R6: late edges
            for (int k = 1; k <= 6; k++) begin
                exp = (k < j + 1) ? k : j + 1;
                edge_at(k, 1'b0, len, off);
                check(len == n + exp, "R6 late length", len, n + exp);
                check(off == 7 + exp, "R6 late sample", off, 7 + exp);
            end
            // R7: early edges
            for (int k = 7; k < 12; k++) begin
                exp = ((n - 1 - k) < j + 1) ? (n - 1 - k) : j + 1;
                edge_at(k, 1'b0, len, off);
                check(len == n - exp, "R7 early length", len, n - exp);
            end
        end

        // R5: hard synchronisation while idle
        for (int k = 1; k < 10; k += 4) begin
            edge_at(k, 1'b1, len, off);
            check(len == k + 1, "R5 hard sync", len, k + 1);
        end

        // R8: second edge in a corrected bit is ignored (J=3)
        start_cfg(8'hC0, {1'b0, 3'd4, 4'd5});
        wait_bs();
        wait_bs();
        wait_ticks(2);
        rx = 1'b0;
        wait_ticks(3);
        rx = 1'b1;
        wait_ticks(3);
        rx = 1'b0;
        wait_bs();
        check(prev_len == n + 2, "R8 one correction", prev_len, n + 2);
        rx = 1'b1;

        // R4 / R3: majority versus single sample; line rises in quantum r
        for (int s = 0; s < 2; s++) begin
            start_cfg(8'h00, {1'(s), 3'd4, 4'd5});
            wait_bs();
            for (int r = 4; r <= 7; r++) begin
                int v4, v5, v6, e;
                wait_bs();
                rx = 1'b0;
                wait_ticks(r);
                rx = 1'b1;
                wait_bs();
                v4 = (4 >= r); v5 = (5 >= r); v6 = (6 >= r);
                e = s ? ((v4 + v5 + v6) >= 2) : v6;
                check(rx_bit == e, s ? "R4 majority" : "R3 single", rx_bit, e);
            end
        end

        // R9: writes while running are ignored, taken after a stop
        start_cfg(8'h00, {1'b0, 3'd4, 4'd5});
        @(negedge clk);
        cfg_b1 = {1'b0, 3'd4, 4'd1};
        wait_bs();
        wait_bs();
        check(prev_len == 12, "R9 running write ignored", prev_len, 12);
        @(negedge clk);
        en = 1'b0;
        begin
            int hits = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (tq_tick || sample_stb || bit_start) hits++;
            end
            check(hits == 0, "R9 quiet while stopped", hits, 0);
        end
        en = 1'b1;
        wait_bs();
        wait_bs();
        check(prev_len == 8, "R9 new config applied", prev_len, 8);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule